// File: doc/BRIEF.md
# Parallel Ciphertext Fault Classifier

This block sits beside a bank of identical cipher instances that all encrypt the same plaintext under the same key. Each time the bank finishes, the block takes one snapshot. The snapshot holds every instance's ciphertext and a known-good reference ciphertext. The block XORs each output with the reference. Any instance whose difference is nonzero is marked as faulty.

The faulty instances are then reported as tagged records, one per cycle, in ascending instance order, under a ready/valid handshake. Each record carries the following:
- the instance index;
- the full difference word;
- the number of bit-sets (0 to 1) and the number of bit-resets (1 to 0);
- a flag that marks the fault as valid, which means it flipped exactly one bit.

Four saturating counters add up the accepted records:
- total bit-sets;
- total bit-resets;
- valid (single-bit) faults;
- invalid (multi-bit) faults.

A synchronous clear input zeroes all four counters.

Top module: `ct_fault_classifier`

## Requirements
- R1: After reset, rec_valid is 0, in_ready is 1 and all four counters read 0.
- R2: A snapshot is taken on a clock edge where in_valid and in_ready are both 1. An instance whose ciphertext (bits [i*CT_W +: CT_W] of inst_ct) equals ref_ct produces no record. Every other instance produces exactly one record, with rec_idx = i and rec_diff = ciphertext XOR ref_ct.
- R3: rec_sets counts the bits where rec_diff is 1 and the reference bit is 0. rec_resets counts the bits where rec_diff is 1 and the reference bit is 1.
- R4: rec_single is 1 exactly when rec_diff has one bit set (a valid fault). It is 0 for any wider nonzero difference (an invalid fault).
- R5: Records of one snapshot appear from the edge after the snapshot, in strictly ascending rec_idx order, one per accepted handshake. While rec_valid is 1 and rec_ready is 0, the record holds steady.
- R6: in_ready is 0 while any record of the current snapshot is still pending. in_valid is ignored in that state.
- R7: On each accepted record, the counters update as follows: cnt_sets grows by rec_sets, cnt_resets grows by rec_resets, and cnt_valid or cnt_invalid (chosen by rec_single) grows by one.
- R8: A counter that would pass 2^CNT_W-1 stays at 2^CNT_W-1.
- R9: clr zeroes all counters on the next edge and wins over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous counter clear |
| in_valid | input | 1 | Snapshot strobe |
| in_ready | output | 1 | High when no record is pending |
| ref_ct | input | CT_W | Known-good ciphertext |
| inst_ct | input | N_INST*CT_W | Packed instance ciphertexts, instance i at [i*CT_W +: CT_W] |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Consumer accepts record |
| rec_idx | output | IDX_W | Faulty instance index |
| rec_diff | output | CT_W | Ciphertext XOR reference |
| rec_sets | output | PC_W | Number of 0-to-1 flips |
| rec_resets | output | PC_W | Number of 1-to-0 flips |
| rec_single | output | 1 | Valid (single-bit) fault flag |
| cnt_sets | output | CNT_W | Accumulated bit-sets |
| cnt_resets | output | CNT_W | Accumulated bit-resets |
| cnt_valid | output | CNT_W | Accumulated valid faults |
| cnt_invalid | output | CNT_W | Accumulated invalid faults |

## Verification
The bench uses a snapshot with faulty instances that are not adjacent and a clean instance between them. A picker that ignores the clean gap, or that serves in the wrong order, shows a wrong rec_idx. A stalled consumer with a second snapshot offered during the drain exposes two faults: a design that overwrites pending state shows extra records, and one that drops state loses records. A reference with mixed bits separates sets from resets, so swapping the polarity gives wrong counts. Running all-ones against all-zeros pushes the counters past their limit, and a wrapping adder then reads small. A clear issued on the same edge as a record handshake catches wrong priority between clear and increment.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ctf_popcnt.sv
module ctf_popcnt #(
  parameter int W    = 64,
  parameter int PC_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec,
  output logic [PC_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + PC_W'(vec[i]);
  end
endmodule

// File: rtl/ctf_classify.sv
module ctf_classify #(
  parameter int CT_W = 64,
  parameter int PC_W = $clog2(CT_W + 1)
) (
  input  logic [CT_W-1:0] diff,
  input  logic [CT_W-1:0] gold,
  output logic [PC_W-1:0] n_sets,
  output logic [PC_W-1:0] n_resets,
  output logic            single
);
  logic [CT_W-1:0] set_mask, rst_mask;
  assign set_mask = diff & ~gold;
  assign rst_mask = diff & gold;

  ctf_popcnt #(.W(CT_W), .PC_W(PC_W)) u_pc_set (.vec(set_mask), .cnt(n_sets));
  ctf_popcnt #(.W(CT_W), .PC_W(PC_W)) u_pc_rst (.vec(rst_mask), .cnt(n_resets));

  logic [PC_W:0] total;
  assign total  = {1'b0, n_sets} + {1'b0, n_resets};
  assign single = (total == (PC_W+1)'(1));
endmodule

// File: rtl/ctf_pick.sv
module ctf_pick #(
  parameter int N     = 4,
  parameter int IDX_W = ctf_pkg::idx_width(N)
) (
  input  logic [N-1:0]     pend,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
  assign any = |pend;
endmodule

// File: rtl/ctf_sat_counter.sv
module ctf_sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] TOP = (SUM_W'(1) << CNT_W) - SUM_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;

  assign sum = SUM_W'(cnt_q) + SUM_W'(inc);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = (sum > TOP) ? TOP[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/ct_fault_classifier.sv
module ct_fault_classifier #(
  parameter int N_INST = 4,
  parameter int CT_W   = 64,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = ctf_pkg::idx_width(N_INST),
  parameter int PC_W   = $clog2(CT_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CT_W-1:0]        ref_ct,
  input  logic [N_INST*CT_W-1:0] inst_ct,
  output logic                   rec_valid,
  input  logic                   rec_ready,
  output logic [IDX_W-1:0]       rec_idx,
  output logic [CT_W-1:0]        rec_diff,
  output logic [PC_W-1:0]        rec_sets,
  output logic [PC_W-1:0]        rec_resets,
  output logic                   rec_single,
  output logic [CNT_W-1:0]       cnt_sets,
  output logic [CNT_W-1:0]       cnt_resets,
  output logic [CNT_W-1:0]       cnt_valid,
  output logic [CNT_W-1:0]       cnt_invalid
);
  logic [CT_W-1:0]   gold_q, gold_d;
  logic [CT_W-1:0]   diff_q [N_INST];
  logic [CT_W-1:0]   diff_d [N_INST];
  logic [CT_W-1:0]   diff_in [N_INST];
  logic [N_INST-1:0] pend_q, pend_d, nz_in, grant;
  logic              any, take, pop;

  for (genvar g = 0; g < N_INST; g++) begin : g_diff
    assign diff_in[g] = inst_ct[g*CT_W +: CT_W] ^ ref_ct;
    assign nz_in[g]   = |diff_in[g];
  end

  ctf_pick #(.N(N_INST), .IDX_W(IDX_W)) u_pick (
    .pend(pend_q), .grant(grant), .idx(rec_idx), .any(any)
  );

  assign in_ready  = ~any;
  assign rec_valid = any;
  assign take      = in_valid & in_ready;
  assign pop       = rec_valid & rec_ready;

  always_comb begin
    gold_d = gold_q;
    pend_d = pend_q;
    for (int i = 0; i < N_INST; i++) diff_d[i] = diff_q[i];
    if (take) begin
      gold_d = ref_ct;
      pend_d = nz_in;
      for (int i = 0; i < N_INST; i++) diff_d[i] = diff_in[i];
    end else if (pop) begin
      pend_d = pend_q & ~grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gold_q <= '0;
      pend_q <= '0;
      for (int i = 0; i < N_INST; i++) diff_q[i] <= '0;
    end else begin
      gold_q <= gold_d;
      pend_q <= pend_d;
      for (int i = 0; i < N_INST; i++) diff_q[i] <= diff_d[i];
    end
  end

  assign rec_diff = diff_q[rec_idx];

  ctf_classify #(.CT_W(CT_W), .PC_W(PC_W)) u_cls (
    .diff(rec_diff), .gold(gold_q),
    .n_sets(rec_sets), .n_resets(rec_resets), .single(rec_single)
  );

  ctf_sat_counter #(.CNT_W(CNT_W), .INC_W(PC_W)) u_cnt_set (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop), .inc(rec_sets), .cnt(cnt_sets)
  );
  ctf_sat_counter #(.CNT_W(CNT_W), .INC_W(PC_W)) u_cnt_rst (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop), .inc(rec_resets), .cnt(cnt_resets)
  );
  ctf_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt_val (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop & rec_single), .inc(1'b1), .cnt(cnt_valid)
  );
  ctf_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt_inv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(pop & ~rec_single), .inc(1'b1), .cnt(cnt_invalid)
  );

  a_r2_nonzero_diff: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_diff != '0);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_idx) && $stable(rec_diff)));
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready) |=> (!rec_valid || rec_idx > $past(rec_idx)));
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !in_ready);
  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_single) |-> $countones(rec_diff) == 1);
endmodule

// File: tb/ct_fault_classifier_bench.sv
module ct_fault_classifier_bench;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 6;
  localparam int IW = 2;
  localparam int PW = 5;
  localparam int TOPV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n, clr, in_valid, rec_ready;
  logic [W-1:0] ref_ct;
  logic [N*W-1:0] inst_ct;
  logic in_ready, rec_valid, rec_single;
  logic [IW-1:0] rec_idx;
  logic [W-1:0] rec_diff;
  logic [PW-1:0] rec_sets, rec_resets;
  logic [CW-1:0] cnt_sets, cnt_resets, cnt_valid, cnt_invalid;

  int total = 0;
  int bad = 0;
  int e_sets = 0, e_resets = 0, e_val = 0, e_inv = 0;

  always #10 clk = ~clk;

  ct_fault_classifier #(.N_INST(N), .CT_W(W), .CNT_W(CW)) u_ct_fault_classifier (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .ref_ct(ref_ct), .inst_ct(inst_ct), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_idx(rec_idx), .rec_diff(rec_diff), .rec_sets(rec_sets), .rec_resets(rec_resets),
    .rec_single(rec_single), .cnt_sets(cnt_sets), .cnt_resets(cnt_resets),
    .cnt_valid(cnt_valid), .cnt_invalid(cnt_invalid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  task automatic chk_counters(input string tag);
    chk({tag, " R7 cnt_sets"}, cnt_sets, e_sets);
    chk({tag, " R7 cnt_resets"}, cnt_resets, e_resets);
    chk({tag, " R7 cnt_valid"}, cnt_valid, e_val);
    chk({tag, " R7 cnt_invalid"}, cnt_invalid, e_inv);
  endtask

  task automatic snap(input logic [W-1:0] r, input logic [N*W-1:0] c);
    ref_ct = r; inst_ct = c; in_valid = 1'b1;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input int idx, input logic [W-1:0] d, input logic [W-1:0] r);
    int s, z;
    s = $countones(d & ~r);
    z = $countones(d & r);
    chk("R2 rec_valid", rec_valid, 1);
    chk("R5 rec_idx", rec_idx, idx);
    chk("R2 rec_diff", rec_diff, d);
    chk("R3 rec_sets", rec_sets, s);
    chk("R3 rec_resets", rec_resets, z);
    chk("R4 rec_single", rec_single, (s + z) == 1);
    rec_ready = 1'b1;
    tick();
    rec_ready = 1'b0;
    e_sets = sat(e_sets + s);
    e_resets = sat(e_resets + z);
    if (s + z == 1) e_val = sat(e_val + 1); else e_inv = sat(e_inv + 1);
  endtask

  task automatic t_reset();
    chk("R1 rec_valid", rec_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk_counters("R1");
  endtask

  task automatic t_clean();
    snap(16'h3C5A, {4{16'h3C5A}});
    chk("R2 clean no record", rec_valid, 0);
    chk("R2 clean in_ready", in_ready, 1);
    chk_counters("R2 clean");
  endtask

  task automatic t_single();
    logic [W-1:0] r = 16'hA5A5;
    snap(r, {r, r ^ 16'h0002, r, r});
    pop_expect(2, 16'h0002, r);
    chk("R5 drained", rec_valid, 0);
    chk_counters("single");
    snap(r, {r, r, r ^ 16'h0100, r});
    pop_expect(1, 16'h0100, r);
    chk_counters("single reset");
  endtask

  task automatic t_multi_stall();
    logic [W-1:0] r = 16'hA5A5;
    snap(r, {r ^ 16'h0101, r, r, r ^ 16'h00F0});
    chk("R6 busy in_ready", in_ready, 0);
    // Offer a new snapshot while stalled; it must be ignored (R6)
    ref_ct = 16'h0000; inst_ct = {4{16'hFFFF}}; in_valid = 1'b1;
    tick(); tick();
    in_valid = 1'b0;
    chk("R5 stall idx held", rec_idx, 0);
    chk("R5 stall diff held", rec_diff, 16'h00F0);
    pop_expect(0, 16'h00F0, r);
    pop_expect(3, 16'h0101, r);
    chk("R6 no extra record", rec_valid, 0);
    chk("R6 in_ready back", in_ready, 1);
    chk_counters("multi");
  endtask

  task automatic t_clear_race();
    logic [W-1:0] r = 16'h0F0F;
    snap(r, {r, r, r, r ^ 16'h0030});
    chk("R9 rec present", rec_valid, 1);
    clr = 1'b1; rec_ready = 1'b1;
    tick();
    clr = 1'b0; rec_ready = 1'b0;
    e_sets = 0; e_resets = 0; e_val = 0; e_inv = 0;
    chk_counters("R9 clear wins");
  endtask

  task automatic t_saturate();
    snap(16'h0000, {4{16'hFFFF}});
    for (int i = 0; i < N; i++) pop_expect(i, 16'hFFFF, 16'h0000);
    chk("R8 cnt_sets saturated", cnt_sets, TOPV);
    snap(16'hFFFF, {4{16'h0000}});
    for (int i = 0; i < N; i++) pop_expect(i, 16'hFFFF, 16'hFFFF);
    chk("R8 cnt_resets saturated", cnt_resets, TOPV);
    chk("R8 cnt_sets stays", cnt_sets, TOPV);
    chk_counters("R8");
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; rec_ready = 1'b0;
    ref_ct = '0; inst_ct = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_clean();
    t_single();
    t_multi_stall();
    t_clear_race();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule